// File: doc/BRIEF.md
# Up/Down Timer Counter with Shadowed Reload

This block is the counting core of a general-purpose timer. A prescaler divides the timer clock into a count clock, and a counter runs either upward from zero to an active reload value or downward from that value to zero. Each wrap can produce an update event, either on every wrap or on every (R+1)-th wrap when a repetition value R is programmed. On an update, the active reload and prescaler values are loaded from their written (preload) copies. The update also sets a sticky interrupt flag that software clears.

Software drives the block through single-cycle write strobes for the reload, prescaler and repetition values. It also has a software update-generate strobe, an update-disable level and a flag-clear strobe. A reload-preload enable picks how a written reload takes effect. When it is off, a written reload applies at once. When it is on, the written value waits in a shadow register until the next update. The counter value and the active reload value are visible at the ports.

Top module: `updn_timer`

## Requirements
- R1: After reset the counter is 0, the active reload value is all ones, the update flag is 0 and the update pulse is 0.
- R2: With `dir_down`=0, each count tick takes the counter from its value to value+1. When the counter is at or above the active reload value, the tick returns it to 0 instead.
- R3: With `dir_down`=1, each count tick takes the counter to value-1. When the counter is 0, the tick reloads it with the active reload value instead.
- R4: A wrap with the repetition down-counter at zero is an update. `upd_pulse` is high for exactly the one cycle in which the counter first shows the wrapped value, and `upd_flag` is set in that same cycle.
- R5: With `arl_pre_en`=0, a reload write becomes the active reload value on the next clock edge. The count tick at that edge uses the new value in the cycles that follow.
- R6: With `arl_pre_en`=1, a reload write leaves `reload_act` unchanged. The written value becomes active only at the next update, so the current period runs to the old value.
- R7: A prescaler value P makes the counter advance once every P+1 clocks while `cnt_en` is high. A written P takes effect only at the next update.
- R8: A repetition value R produces an update on every (R+1)-th wrap. A written R takes effect at the next update.
- R9: A `sw_upd` strobe (with `upd_dis`=0) produces an update. It sets the counter to 0 in up mode, or to the new active reload value in down mode. It also restarts the prescaler divider and reloads the repetition down-counter.
- R10: While `upd_dis`=1, wraps and `sw_upd` give no update pulse, no flag set and no load of `reload_act`. The counter still wraps, and `sw_upd` leaves the counter unchanged.
- R11: `upd_flag` stays set until a `flag_clr` strobe. If a clear and an update happen in the same cycle, the flag ends up set.
- R12: With `cnt_en`=0 and no accepted `sw_upd`, the counter holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Counter enable |
| dir_down | input | 1 | 0 = count up, 1 = count down |
| arl_pre_en | input | 1 | 1 = reload writes go through the shadow register |
| upd_dis | input | 1 | 1 = update events suppressed |
| sw_upd | input | 1 | Software update-generate strobe |
| flag_clr | input | 1 | Software clear strobe for the update flag |
| wr_reload | input | 1 | Reload value write strobe |
| wr_reload_val | input | CNT_W | Reload value to write |
| wr_psc | input | 1 | Prescaler write strobe |
| wr_psc_val | input | PSC_W | Prescaler value to write |
| wr_rep | input | 1 | Repetition value write strobe |
| wr_rep_val | input | REP_W | Repetition value to write |
| count | output | CNT_W | Current counter value |
| reload_act | output | CNT_W | Active reload value |
| upd_pulse | output | 1 | One-cycle update event |
| upd_flag | output | 1 | Sticky update interrupt flag |

## Verification
The counter is first driven in both directions with a small reload value, so the wrap targets 0 and the reload value can be compared directly. A reload change from 0x65 to 0x63 while the counter is at 0x62 is applied once with preload off and once with preload on. The first run must wrap after 0x63 and the second after 0x65, which separates immediate loading from shadowed loading. A prescaler of 1, checked before and after the update that applies it, separates divided counting from pending values. A repetition of 2, observed over 24 ticks, must give updates only at ticks 12 and 24, which tells gated wraps apart from plain wraps. Finally, the same wrap and software strobe are repeated with updates disabled, to show that the pulse, the flag and the reload are suppressed while the counter keeps running.

// File: rtl/tmr_pkg.sv
// Shared types for the up/down timer.
// Assumes: nothing beyond IEEE 1800-2017.
package tmr_pkg;
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } cnt_dir_e;
endpackage

// File: rtl/tmr_presc.sv
// Prescaler: divides the timer clock by (active value + 1) into a count tick.
// Assumes: the preload copy is moved to the active copy only on an update;
// a restart clears the divider so the next period begins from zero.
module tmr_presc #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             psc_wr,
    input  logic [PSC_W-1:0] psc_wr_val,
    input  logic             load,
    input  logic             restart,
    output logic             tick
);
    logic [PSC_W-1:0] psc_pre;
    logic [PSC_W-1:0] psc_act;
    logic [PSC_W-1:0] div_q;

    assign tick = en && (div_q == psc_act);

    // Keep the written and active prescaler values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_pre <= '0;
            psc_act <= '0;
        end else begin
            if (psc_wr) psc_pre <= psc_wr_val;
            if (load)   psc_act <= psc_pre;
        end
    end

    // Advance the divider, clearing it on a tick or a restart.
    always_ff @(posedge clk) begin
        if (!rst_n)       div_q <= '0;
        else if (restart) div_q <= '0;
        else if (en)      div_q <= tick ? '0 : div_q + 1'b1;
    end
endmodule

// File: rtl/tmr_rep.sv
// Repetition gate: lets one wrap in (R+1) through as an update.
// Assumes: a written R is picked up when the down-counter reloads, which
// happens at a gated wrap or at an accepted software update.
module tmr_rep #(
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wrap,
    input  logic             reinit,
    input  logic             rep_wr,
    input  logic [REP_W-1:0] rep_wr_val,
    output logic             rep_zero
);
    logic [REP_W-1:0] rep_pre;
    logic [REP_W-1:0] rep_cnt;

    assign rep_zero = (rep_cnt == '0);

    // Store the written repetition value.
    always_ff @(posedge clk) begin
        if (!rst_n)      rep_pre <= '0;
        else if (rep_wr) rep_pre <= rep_wr_val;
    end

    // Count wraps down and reload at zero or on software update.
    always_ff @(posedge clk) begin
        if (!rst_n)      rep_cnt <= '0;
        else if (reinit) rep_cnt <= rep_pre;
        else if (wrap)   rep_cnt <= rep_zero ? rep_pre : rep_cnt - 1'b1;
    end
endmodule

// File: rtl/tmr_core.sv
// Counter core: up/down count with a reload value that is either written
// straight through or held in a shadow until the next update.
// Assumes: tick is a single-cycle enable; gen is an accepted software update
// and takes priority over a tick in the same cycle.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             dir_down,
    input  logic             pre_en,
    input  logic             reload_wr,
    input  logic [CNT_W-1:0] reload_wr_val,
    input  logic             upd,
    input  logic             gen,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload_act,
    output logic             wrap
);
    cnt_dir_e         dir;
    logic [CNT_W-1:0] arl_pre;
    logic [CNT_W-1:0] arl_nxt;
    logic [CNT_W-1:0] cnt_nxt;

    assign dir = cnt_dir_e'(dir_down);

    // Detect the end of a period in the selected direction.
    always_comb begin
        if (dir == DIR_DOWN) wrap = tick && (count == '0);
        else                 wrap = tick && (count >= reload_act);
    end

    // Pick the reload value that is active after this edge.
    always_comb begin
        if (reload_wr && !pre_en) arl_nxt = reload_wr_val;
        else if (upd)             arl_nxt = arl_pre;
        else                      arl_nxt = reload_act;
    end

    // Pick the next counter value.
    always_comb begin
        cnt_nxt = count;
        if (gen) begin
            cnt_nxt = (dir == DIR_DOWN) ? arl_nxt : '0;
        end else if (tick) begin
            if (wrap)                 cnt_nxt = (dir == DIR_DOWN) ? arl_nxt : '0;
            else if (dir == DIR_DOWN) cnt_nxt = count - 1'b1;
            else                      cnt_nxt = count + 1'b1;
        end
    end

    // Register the counter, the shadow and the active reload value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count      <= '0;
            arl_pre    <= '1;
            reload_act <= '1;
        end else begin
            count      <= cnt_nxt;
            reload_act <= arl_nxt;
            if (reload_wr) arl_pre <= reload_wr_val;
        end
    end
endmodule

// File: rtl/updn_timer.sv
// Up/down timer top: joins prescaler, counter core and repetition gate,
// forms the update event and keeps the sticky update flag.
// Assumes: all strobes are single-cycle and synchronous to clk.
module updn_timer #(
    parameter int CNT_W = 16,
    parameter int PSC_W = 16,
    parameter int REP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic             dir_down,
    input  logic             arl_pre_en,
    input  logic             upd_dis,
    input  logic             sw_upd,
    input  logic             flag_clr,
    input  logic             wr_reload,
    input  logic [CNT_W-1:0] wr_reload_val,
    input  logic             wr_psc,
    input  logic [PSC_W-1:0] wr_psc_val,
    input  logic             wr_rep,
    input  logic [REP_W-1:0] wr_rep_val,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] reload_act,
    output logic             upd_pulse,
    output logic             upd_flag
);
    logic tick;
    logic wrap;
    logic rep_zero;
    logic gen_ok;
    logic upd;

    assign gen_ok = sw_upd && !upd_dis;
    assign upd    = !upd_dis && ((wrap && rep_zero) || sw_upd);

    tmr_presc #(.PSC_W(PSC_W)) u_presc (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (cnt_en),
        .psc_wr     (wr_psc),
        .psc_wr_val (wr_psc_val),
        .load       (upd),
        .restart    (gen_ok),
        .tick       (tick)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .dir_down      (dir_down),
        .pre_en        (arl_pre_en),
        .reload_wr     (wr_reload),
        .reload_wr_val (wr_reload_val),
        .upd           (upd),
        .gen           (gen_ok),
        .count         (count),
        .reload_act    (reload_act),
        .wrap          (wrap)
    );

    tmr_rep #(.REP_W(REP_W)) u_rep (
        .clk        (clk),
        .rst_n      (rst_n),
        .wrap       (wrap),
        .reinit     (gen_ok),
        .rep_wr     (wr_rep),
        .rep_wr_val (wr_rep_val),
        .rep_zero   (rep_zero)
    );

    // Register the update pulse and keep the flag, set winning over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_pulse <= 1'b0;
            upd_flag  <= 1'b0;
        end else begin
            upd_pulse <= upd;
            if (upd)           upd_flag <= 1'b1;
            else if (flag_clr) upd_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/updn_timer_chk.sv
// Checker for updn_timer, bound to every instance of the top.
// Assumes: synchronous active-low reset; properties are off while in reset.
module updn_timer_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             dir_down,
    input logic             arl_pre_en,
    input logic             upd_dis,
    input logic             sw_upd,
    input logic             flag_clr,
    input logic             wr_reload,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] reload_act,
    input logic             upd_pulse,
    input logic             upd_flag
);
    // R2: an up step is hold, +1 or a return to zero
    p_up_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!dir_down && !(sw_upd && !upd_dis)) |=>
        ($stable(count) || count == CNT_W'($past(count) + 1'b1) || count == '0));

    // R3: a down step is hold, -1 or a reload
    p_down_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dir_down && !(sw_upd && !upd_dis) && !wr_reload) |=>
        ($stable(count) || count == CNT_W'($past(count) - 1'b1) || count == reload_act));

    // R4: an update pulse always shows the flag set
    p_pulse_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        upd_pulse |-> upd_flag);

    // R6: with preload on the active reload changes only with an update
    p_shadow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        arl_pre_en |=> ($stable(reload_act) || upd_pulse));

    // R10: no update pulse while updates are disabled
    p_no_upd_r10: assert property (@(posedge clk) disable iff (!rst_n)
        upd_dis |=> !upd_pulse);

    // R11: the flag stays set without a clear
    p_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_flag && !flag_clr) |=> upd_flag);

    // R12: the counter holds while disabled and no software update is taken
    p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !(sw_upd && !upd_dis)) |=> $stable(count));
endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_en     (cnt_en),
    .dir_down   (dir_down),
    .arl_pre_en (arl_pre_en),
    .upd_dis    (upd_dis),
    .sw_upd     (sw_upd),
    .flag_clr   (flag_clr),
    .wr_reload  (wr_reload),
    .count      (count),
    .reload_act (reload_act),
    .upd_pulse  (upd_pulse),
    .upd_flag   (upd_flag)
);

// File: tb/sim_updn_timer.sv
// Directed bench for updn_timer: one task per scenario, each checking itself.
module sim_updn_timer;
    localparam int CNT_W = 16;
    localparam int PSC_W = 16;
    localparam int REP_W = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             cnt_en, dir_down, arl_pre_en, upd_dis, sw_upd, flag_clr;
    logic             wr_reload, wr_psc, wr_rep;
    logic [CNT_W-1:0] wr_reload_val;
    logic [PSC_W-1:0] wr_psc_val;
    logic [REP_W-1:0] wr_rep_val;
    logic [CNT_W-1:0] count, reload_act;
    logic             upd_pulse, upd_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    updn_timer #(.CNT_W(CNT_W), .PSC_W(PSC_W), .REP_W(REP_W)) u0 (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .dir_down(dir_down),
        .arl_pre_en(arl_pre_en), .upd_dis(upd_dis), .sw_upd(sw_upd),
        .flag_clr(flag_clr), .wr_reload(wr_reload), .wr_reload_val(wr_reload_val),
        .wr_psc(wr_psc), .wr_psc_val(wr_psc_val), .wr_rep(wr_rep),
        .wr_rep_val(wr_rep_val), .count(count), .reload_act(reload_act),
        .upd_pulse(upd_pulse), .upd_flag(upd_flag)
    );

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_reload(input int v);
        wr_reload = 1'b1; wr_reload_val = CNT_W'(v); step(1); wr_reload = 1'b0;
    endtask

    task automatic put_psc(input int v);
        wr_psc = 1'b1; wr_psc_val = PSC_W'(v); step(1); wr_psc = 1'b0;
    endtask

    task automatic put_rep(input int v);
        wr_rep = 1'b1; wr_rep_val = REP_W'(v); step(1); wr_rep = 1'b0;
    endtask

    task automatic gen_upd();
        sw_upd = 1'b1; step(1); sw_upd = 1'b0;
    endtask

    task automatic clr_flag();
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 count", int'(count), 0);
        chk("R1 reload_act", int'(reload_act), 16'hffff);
        chk("R1 flag", int'(upd_flag), 0);
        chk("R1 pulse", int'(upd_pulse), 0);
    endtask

    task automatic t_up_wrap();
        put_reload(5);
        chk("R5 immediate reload", int'(reload_act), 5);
        dir_down = 1'b0; cnt_en = 1'b1;
        step(5);
        chk("R2 count at top", int'(count), 5);
        chk("R4 no flag before wrap", int'(upd_flag), 0);
        step(1);
        chk("R2 wrap to zero", int'(count), 0);
        chk("R4 pulse on wrap", int'(upd_pulse), 1);
        chk("R4 flag on wrap", int'(upd_flag), 1);
        step(1);
        chk("R4 pulse one cycle", int'(upd_pulse), 0);
        chk("R11 flag sticky", int'(upd_flag), 1);
        chk("R2 count after wrap", int'(count), 1);
        cnt_en = 1'b0;
    endtask

    task automatic t_flag();
        clr_flag();
        chk("R11 flag cleared", int'(upd_flag), 0);
        cnt_en = 1'b1;
        step(4);
        chk("R2 count before wrap", int'(count), 5);
        flag_clr = 1'b1;
        step(1);
        flag_clr = 1'b0;
        cnt_en = 1'b0;
        chk("R11 set beats clear", int'(upd_flag), 1);
        chk("R2 wrapped with clear", int'(count), 0);
    endtask

    task automatic t_hold();
        cnt_en = 1'b1; step(3); cnt_en = 1'b0;
        step(4);
        chk("R12 hold while disabled", int'(count), 3);
    endtask

    task automatic t_sw_up();
        gen_upd();
        chk("R9 up sw update clears count", int'(count), 0);
        chk("R9 sw update pulse", int'(upd_pulse), 1);
    endtask

    task automatic t_down();
        dir_down = 1'b1;
        gen_upd();
        chk("R9 down sw update loads reload", int'(count), 5);
        cnt_en = 1'b1;
        step(1);
        chk("R3 down step", int'(count), 4);
        step(4);
        chk("R3 down at zero", int'(count), 0);
        chk("R3 no pulse at zero", int'(upd_pulse), 0);
        step(1);
        chk("R3 restart from reload", int'(count), 5);
        chk("R4 pulse on underflow", int'(upd_pulse), 1);
        cnt_en = 1'b0; dir_down = 1'b0;
    endtask

    task automatic t_immediate();
        arl_pre_en = 1'b0;
        put_reload(16'h65);
        gen_upd();
        cnt_en = 1'b1;
        step(16'h62);
        chk("R5 reached 62", int'(count), 16'h62);
        wr_reload = 1'b1; wr_reload_val = 16'h63;
        step(1);
        wr_reload = 1'b0;
        chk("R5 count 63", int'(count), 16'h63);
        chk("R5 new reload active", int'(reload_act), 16'h63);
        step(1);
        chk("R5 wrap after 63", int'(count), 0);
        chk("R5 pulse", int'(upd_pulse), 1);
        cnt_en = 1'b0;
    endtask

    task automatic t_preload();
        arl_pre_en = 1'b1;
        put_reload(16'h65);
        chk("R6 write held in shadow", int'(reload_act), 16'h63);
        gen_upd();
        chk("R6 shadow loaded on update", int'(reload_act), 16'h65);
        cnt_en = 1'b1;
        step(16'h62);
        wr_reload = 1'b1; wr_reload_val = 16'h63;
        step(1);
        wr_reload = 1'b0;
        chk("R6 old reload kept", int'(reload_act), 16'h65);
        step(2);
        chk("R6 runs to 65", int'(count), 16'h65);
        step(1);
        chk("R6 wrap after 65", int'(count), 0);
        chk("R6 new reload after update", int'(reload_act), 16'h63);
        cnt_en = 1'b0;
    endtask

    task automatic t_psc();
        put_reload(9);
        put_psc(1);
        cnt_en = 1'b1;
        step(2);
        cnt_en = 1'b0;
        chk("R7 new prescaler pending", int'(count), 2);
        gen_upd();
        cnt_en = 1'b1;
        step(1);
        chk("R7 no tick first clock", int'(count), 0);
        step(1);
        chk("R7 tick second clock", int'(count), 1);
        step(2);
        chk("R7 divided by two", int'(count), 2);
        cnt_en = 1'b0;
    endtask

    task automatic t_rep();
        int first = 0;
        int hits  = 0;
        arl_pre_en = 1'b0;
        put_psc(0);
        put_rep(2);
        put_reload(3);
        gen_upd();
        cnt_en = 1'b1;
        for (int i = 1; i <= 24; i++) begin
            step(1);
            if (upd_pulse) begin
                hits++;
                if (first == 0) first = i;
            end
        end
        cnt_en = 1'b0;
        chk("R8 first update at tick 12", first, 12);
        chk("R8 two updates in 24 ticks", hits, 2);
    endtask

    task automatic t_dis();
        int pulses = 0;
        put_rep(0);
        gen_upd();
        clr_flag();
        upd_dis = 1'b1;
        arl_pre_en = 1'b1;
        put_reload(7);
        cnt_en = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            step(1);
            if (upd_pulse) pulses++;
        end
        cnt_en = 1'b0;
        chk("R10 counter still wraps", int'(count), 2);
        chk("R10 no pulse", pulses, 0);
        chk("R10 no flag", int'(upd_flag), 0);
        chk("R10 no shadow load", int'(reload_act), 3);
        gen_upd();
        chk("R10 sw update ignored count", int'(count), 2);
        chk("R10 sw update ignored pulse", int'(upd_pulse), 0);
        upd_dis = 1'b0;
        gen_upd();
        chk("R9 update after re-enable loads shadow", int'(reload_act), 7);
        chk("R9 update after re-enable sets flag", int'(upd_flag), 1);
    endtask

    initial begin
        rst_n = 1'b0;
        cnt_en = 1'b0; dir_down = 1'b0; arl_pre_en = 1'b0; upd_dis = 1'b0;
        sw_upd = 1'b0; flag_clr = 1'b0; wr_reload = 1'b0; wr_psc = 1'b0;
        wr_rep = 1'b0; wr_reload_val = '0; wr_psc_val = '0; wr_rep_val = '0;
        step(3);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_up_wrap();
        t_flag();
        t_hold();
        t_sw_up();
        t_down();
        t_immediate();
        t_preload();
        t_psc();
        t_rep();
        t_dis();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule